// File: doc/BRIEF.md
# SMBus Clock-Timing Interface Reset Monitor

This block watches a synchronized bus clock line together with start and stop event pulses and raises a single-cycle reset pulse for the slave interface state machine when the bus master requests a reset through clock timing alone. Two conditions trigger that reset. The first is the total time the clock spends low inside a transaction. This total is summed over every low phase between a start and the following stop, so short high phases do not restart it. The second is an unbroken stretch of clock-high time.

Time is measured in ticks. A tick is either a one-cycle enable supplied on `tick_i`, or one generated inside the block every `TICK_DIV` system cycles when that parameter is non-zero. The defaults `LOW_LIMIT = 25` and `HIGH_LIMIT = 50` give 25 ms and 50 ms with a 1 ms tick. Both limits must be at least 2.

The low accumulator has two states. `LA_IDLE` means outside a transaction. `LA_ACTIVE` means inside one and summing. Its transitions are:
- *open*: start pulse, from `LA_IDLE` to `LA_ACTIVE`.
- *restart*: start pulse, from `LA_ACTIVE` back to `LA_ACTIVE` with the sum cleared.
- *close*: stop pulse, from `LA_ACTIVE` to `LA_IDLE`.
- *expire*: the final low tick, from `LA_ACTIVE` to `LA_IDLE` with a reset.
- *flush*: a clock-high timeout, from any state to `LA_IDLE`.

The high timer has three states. `HT_LOW` means the clock is low. `HT_COUNT` means the clock is high and the timer is counting. `HT_SPENT` means a high timeout has fired and the timer waits for the clock to fall. Its transitions are:
- *rise*: `HT_LOW` to `HT_COUNT` when the clock is seen high.
- *fall*: `HT_COUNT` or `HT_SPENT` to `HT_LOW` when the clock is seen low.
- *expire*: `HT_COUNT` to `HT_SPENT` on the final high tick.
- *flush*: a low timeout, from any state to `HT_LOW`.

Top module: `smb_clk_timeout_rst`

## Requirements
- R1: Inside a transaction, every cycle with `scl_i` low and a tick adds one to a low sum. Ticks while `scl_i` is high add nothing and do not clear the sum. When the sum reaches `LOW_LIMIT`, a reset pulse is produced.
- R2: Ticks with `scl_i` low before any start pulse, or after a stop pulse, are ignored. No reset results from them, however many there are.
- R3: A stop pulse clears the low sum and ends the transaction. A start pulse clears the sum and opens a transaction. A stop or start pulse that falls in the same cycle as the tick that would reach `LOW_LIMIT` wins, and no reset follows. When start and stop arrive together, the start wins.
- R4: When `scl_i` is high for `HIGH_LIMIT` ticks with no low cycle in between, a reset pulse is produced. Any cycle with `scl_i` low clears the high count.
- R5: `bus_rst_o` is high for exactly one cycle per timeout. After a high timeout, no further pulse comes until `scl_i` has been low. After a low timeout, both counts are cleared, and no further low-time pulse comes before a new start pulse.
- R6: `bus_rst_o` rises in the cycle that follows the clock edge at which the final tick is sampled.
- R7: After `rst_n` is released, `bus_rst_o` is 0 and neither count holds time.
- R8: With `TICK_DIV` greater than 0, a tick is made internally once every `TICK_DIV` cycles, counted from reset, and `tick_i` is ignored. With `scl_i` held high from reset, the first pulse is visible after `HIGH_LIMIT*TICK_DIV` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, already synchronized to `clk` |
| start_i | input | 1 | One-cycle pulse for a detected start or repeated start |
| stop_i | input | 1 | One-cycle pulse for a detected stop |
| tick_i | input | 1 | Time-base enable, one cycle per tick (used when `TICK_DIV` is 0) |
| bus_rst_o | output | 1 | One-cycle reset request to the slave state machine |

## Verification
The two functions that can meet in one cycle are the expiry of the low sum and a stop or start event. The bench delivers a stop pulse, and in a separate case a start pulse, in exactly the cycle of the tick that would bring the sum to `LOW_LIMIT`. It then requires `bus_rst_o` to stay low, and after the start case it requires a full fresh `LOW_LIMIT` ticks before the pulse appears. Random stimulus with frequent start and stop pulses and dense ticks produces many more of these coincidences. Each of them is judged cycle by cycle against the bench's own model of the two counters.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

    typedef enum logic {
        LA_IDLE,
        LA_ACTIVE
    } low_st_e;

    typedef enum logic [1:0] {
        HT_LOW,
        HT_COUNT,
        HT_SPENT
    } high_st_e;

endpackage

// File: rtl/smb_tmo_tick.sv
module smb_tmo_tick #(
    parameter int TICK_DIV = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic tick_o
);

    generate
        if (TICK_DIV == 0) begin : g_ext
            assign tick_o = tick_i;
        end else begin : g_div
            localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
            localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
            logic [DW-1:0] div_cnt;
            logic          unused_tick_in;

            assign unused_tick_in = tick_i;
            assign tick_o         = (div_cnt == LAST);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                end else if (div_cnt == LAST) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end

            if (TICK_DIV > 1) begin : g_chk
                // R8: internal ticks are spaced, never back to back
                assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    tick_o |=> !tick_o);
            end
        end
    endgenerate

endmodule

// File: rtl/smb_tmo_low.sv
module smb_tmo_low
    import smb_tmo_pkg::*;
#(
    parameter int LOW_LIMIT = 25,
    parameter int CNT_W     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_i,
    input  logic flush_i,
    output logic fire_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOW_LIMIT - 1);

    low_st_e          state, nxt;
    logic [CNT_W-1:0] lo_cnt;
    logic             low_tick;

    assign low_tick = tick_i && !scl_i;

    // final low tick; start, stop and flush all take precedence
    always_comb begin
        fire_o = (state == LA_ACTIVE) && !flush_i && !start_i && !stop_i
                 && low_tick && (lo_cnt == LAST);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LA_IDLE: begin
                if (!flush_i && start_i) nxt = LA_ACTIVE;        // open
            end
            LA_ACTIVE: begin
                if (flush_i)       nxt = LA_IDLE;                // flush
                else if (start_i)  nxt = LA_ACTIVE;              // restart
                else if (stop_i)   nxt = LA_IDLE;                // close
                else if (fire_o)   nxt = LA_IDLE;                // expire
            end
            default: nxt = LA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LA_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
        end else if (flush_i || start_i || stop_i || fire_o) begin
            lo_cnt <= '0;
        end else if ((state == LA_ACTIVE) && low_tick) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R1: the sum never passes the limit
    assert_low_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt < CNT_W'(LOW_LIMIT));

    // R1: a high phase inside a transaction keeps the sum
    assert_low_hold_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == LA_ACTIVE) && scl_i && !start_i && !stop_i && !flush_i) |=> $stable(lo_cnt));

    // R2: outside a transaction nothing accumulates
    assert_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == LA_IDLE) && !start_i) |=> (lo_cnt == '0));

    // R3: a stop without a start closes the transaction with a cleared sum
    assert_low_stop_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> ((state == LA_IDLE) && (lo_cnt == '0)));

endmodule

// File: rtl/smb_tmo_high.sv
module smb_tmo_high
    import smb_tmo_pkg::*;
#(
    parameter int HIGH_LIMIT = 50,
    parameter int CNT_W      = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic tick_i,
    input  logic flush_i,
    output logic fire_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HIGH_LIMIT - 1);

    high_st_e         state, nxt;
    logic [CNT_W-1:0] hi_cnt;

    always_comb begin
        fire_o = (state == HT_COUNT) && !flush_i && scl_i && tick_i
                 && (hi_cnt == LAST);
    end

    always_comb begin
        nxt = state;
        if (flush_i) begin
            nxt = HT_LOW;                                        // flush
        end else begin
            unique case (state)
                HT_LOW:   if (scl_i) nxt = HT_COUNT;             // rise
                HT_COUNT: begin
                    if (!scl_i)      nxt = HT_LOW;               // fall
                    else if (fire_o) nxt = HT_SPENT;             // expire
                end
                HT_SPENT: if (!scl_i) nxt = HT_LOW;              // fall
                default:  nxt = HT_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HT_LOW;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (flush_i || (state != HT_COUNT) || !scl_i || fire_o) begin
            hi_cnt <= '0;
        end else if (tick_i) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R4: a low cycle clears the high count
    assert_high_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_i |=> (hi_cnt == '0));

    // R4: the count never passes the limit
    assert_high_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt < CNT_W'(HIGH_LIMIT));

    // R5: once spent, no counting until the clock falls
    assert_high_spent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == HT_SPENT) && scl_i && !flush_i) |=> ((state == HT_SPENT) && (hi_cnt == '0)));

endmodule

// File: rtl/smb_clk_timeout_rst.sv
module smb_clk_timeout_rst #(
    parameter int LOW_LIMIT  = 25,
    parameter int HIGH_LIMIT = 50,
    parameter int TICK_DIV   = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_i,
    output logic bus_rst_o
);

    localparam int LOW_W  = $clog2(LOW_LIMIT + 1);
    localparam int HIGH_W = $clog2(HIGH_LIMIT + 1);

    logic tick;
    logic low_fire;
    logic high_fire;

    smb_tmo_tick #(
        .TICK_DIV (TICK_DIV)
    ) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .tick_o (tick)
    );

    smb_tmo_low #(
        .LOW_LIMIT (LOW_LIMIT),
        .CNT_W     (LOW_W)
    ) i_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .start_i (start_i),
        .stop_i  (stop_i),
        .tick_i  (tick),
        .flush_i (high_fire),
        .fire_o  (low_fire)
    );

    smb_tmo_high #(
        .HIGH_LIMIT (HIGH_LIMIT),
        .CNT_W      (HIGH_W)
    ) i_high (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .tick_i  (tick),
        .flush_i (low_fire),
        .fire_o  (high_fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) bus_rst_o <= 1'b0;
        else        bus_rst_o <= low_fire || high_fire;
    end

    // R5: a reset request never lasts two cycles
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |=> !bus_rst_o);

    // R3: a stop seen with the clock low never leads to a reset
    assert_stop_no_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i && !scl_i) |=> !bus_rst_o);

    // R6: a pulse always follows a sampled tick
    assert_pulse_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !bus_rst_o);

endmodule

// File: tb/test_smb_clk_timeout_rst.sv
module test_smb_clk_timeout_rst;

    localparam int CLK_P = 10;
    localparam int LO    = 5;
    localparam int HI    = 8;
    localparam int DIV2  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, start_p = 1'b0, stop_p = 1'b0, tick = 1'b0;
    logic bus_rst, bus_rst_div;

    int n_tests = 0, n_fail = 0, div_pulses = 0;
    bit done = 1'b0;
    string cur_req = "R7";

    // model state
    bit m_in_tr;
    int m_low, m_high, m_hst; // m_hst: 0 low, 1 counting, 2 spent
    bit m_exp;

    always #(CLK_P/2) clk = ~clk;

    smb_clk_timeout_rst #(.LOW_LIMIT(LO), .HIGH_LIMIT(HI), .TICK_DIV(0)) i_smb_clk_timeout_rst (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .start_i(start_p), .stop_i(stop_p),
        .tick_i(tick), .bus_rst_o(bus_rst));

    smb_clk_timeout_rst #(.LOW_LIMIT(LO), .HIGH_LIMIT(HI), .TICK_DIV(DIV2)) i_smb_clk_timeout_rst_div (
        .clk(clk), .rst_n(rst_n), .scl_i(1'b1), .start_i(1'b0), .stop_i(1'b0),
        .tick_i(tick), .bus_rst_o(bus_rst_div));

    task automatic check(input logic act, input logic exp, input string msg);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", cur_req, msg, act, exp);
        end
    endtask

    function automatic bit low_fires(bit s, bit st, bit sp, bit tk);
        return m_in_tr && !st && !sp && tk && !s && (m_low == LO - 1);
    endfunction

    function automatic bit high_fires(bit s, bit tk);
        return (m_hst == 1) && s && tk && (m_high == HI - 1);
    endfunction

    task automatic model_reset();
        m_in_tr = 0; m_low = 0; m_high = 0; m_hst = 0; m_exp = 0;
    endtask

    task automatic model_update(input bit s, input bit st, input bit sp, input bit tk);
        bit lf, hf;
        lf = low_fires(s, st, sp, tk);
        hf = high_fires(s, tk);
        if (hf) begin
            m_in_tr = 0; m_low = 0;
        end else if (st) begin
            m_in_tr = 1; m_low = 0;
        end else if (sp) begin
            m_in_tr = 0; m_low = 0;
        end else if (m_in_tr && tk && !s) begin
            if (lf) begin m_in_tr = 0; m_low = 0; end
            else m_low++;
        end
        if (lf) begin
            m_hst = 0; m_high = 0;
        end else begin
            case (m_hst)
                0: if (s) begin m_hst = 1; m_high = 0; end
                1: if (!s) begin m_hst = 0; m_high = 0; end
                   else if (tk) begin
                       if (hf) begin m_hst = 2; m_high = 0; end
                       else m_high++;
                   end
                default: if (!s) begin m_hst = 0; m_high = 0; end
            endcase
        end
        m_exp = lf || hf;
    endtask

    // drive at negedge, sample just after posedge, return at negedge
    task automatic step(input bit s, input bit st, input bit sp, input bit tk);
        scl = s; start_p = st; stop_p = sp; tick = tk;
        model_update(s, st, sp, tk);
        @(posedge clk);
        #1;
        check(bus_rst, m_exp, "model compare");
        if (bus_rst_div) div_pulses++;
        @(negedge clk);
    endtask

    task automatic run(input bit s, input int n, input bit tk);
        for (int i = 0; i < n; i++) step(s, 1'b0, 1'b0, tk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R7";
        #1;
        check(bus_rst, 1'b0, "output after reset");

        // R8: divided tick, scl held high from reset
        cur_req = "R8";
        n = 0;
        while (n < 200) begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            n++;
            if (bus_rst_div) break;
        end
        check(n == HI * DIV2, 1'b1, "divided tick edge count");
        check(bus_rst, 1'b0, "main block idle without ticks");

        // R4: continuous high timeout
        cur_req = "R4";
        run(1'b1, HI - 1, 1'b1);
        check(bus_rst, 1'b0, "high one tick short");
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check(bus_rst, 1'b1, "high timeout pulse");

        // R5: spent, no repeat while high
        cur_req = "R5";
        run(1'b1, 12, 1'b1);
        check(bus_rst, 1'b0, "no repeat while high");

        // R4: a single low cycle clears the high count
        cur_req = "R4";
        step(1'b0, 1'b0, 1'b0, 1'b0);
        run(1'b1, HI - 1, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        run(1'b1, HI - 1, 1'b1);
        check(bus_rst, 1'b0, "low cycle clears high count");
        step(1'b0, 1'b0, 1'b0, 1'b0);

        // R2: low ticks outside a transaction ignored
        cur_req = "R2";
        run(1'b0, 3 * LO, 1'b1);
        check(bus_rst, 1'b0, "low outside transaction");

        // R1 and R6: cumulative low across a high phase
        cur_req = "R1";
        step(1'b1, 1'b1, 1'b0, 1'b0);
        run(1'b0, 3, 1'b1);
        run(1'b1, 3, 1'b1);
        run(1'b0, LO - 4, 1'b1);
        cur_req = "R6";
        check(bus_rst, 1'b0, "one low tick short");
        step(1'b0, 1'b0, 1'b0, 1'b1);
        cur_req = "R1";
        check(bus_rst, 1'b1, "cumulative low pulse");

        // R5: no second pulse after low timeout
        cur_req = "R5";
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check(bus_rst, 1'b0, "pulse lasts one cycle");
        run(1'b0, 2 * LO, 1'b1);
        check(bus_rst, 1'b0, "no low pulse until new start");
        step(1'b1, 1'b0, 1'b1, 1'b0);

        // R3: stop clears, restart from zero
        cur_req = "R3";
        step(1'b1, 1'b1, 1'b0, 1'b0);
        run(1'b0, LO - 1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        run(1'b0, LO - 1, 1'b1);
        check(bus_rst, 1'b0, "stop cleared low sum");
        // stop coincides with the final tick
        step(1'b0, 1'b0, 1'b1, 1'b1);
        check(bus_rst, 1'b0, "stop beats final tick");
        // start coincides with the final tick
        step(1'b1, 1'b1, 1'b0, 1'b0);
        run(1'b0, LO - 1, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        check(bus_rst, 1'b0, "start beats final tick");
        run(1'b0, LO - 1, 1'b1);
        check(bus_rst, 1'b0, "sum restarted by start");
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check(bus_rst, 1'b1, "pulse after full fresh sum");
        // start and stop together: start wins
        step(1'b1, 1'b1, 1'b1, 1'b0);
        run(1'b0, LO, 1'b1);
        check(bus_rst, 1'b1, "start wins over stop");

        // random phase
        cur_req = "R1";
        for (int k = 0; k < 4000; k++) begin
            bit s;
            int len;
            s = 1'($urandom_range(0, 1));
            len = $urandom_range(1, 12);
            for (int j = 0; j < len; j++) begin
                step(s, ($urandom_range(0, 39) == 0), ($urandom_range(0, 39) == 0),
                     1'($urandom_range(0, 1)));
            end
            if (k > 200) break;
        end
        for (int k = 0; k < 3000; k++) begin
            step(($urandom_range(0, 5) != 0) ? scl : ~scl,
                 ($urandom_range(0, 29) == 0), ($urandom_range(0, 29) == 0),
                 ($urandom_range(0, 2) != 0));
        end

        cur_req = "R8";
        check(div_pulses == 1, 1'b1, "divided instance pulsed once, tick_i ignored");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule